// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting channel of an interval timer. It holds a count register loaded by software and a counting element that steps down once per clock-enable tick, counting either in plain binary or as four packed decimal digits. Six operating modes set how the count is armed, whether it reloads, and the shape of the output: a single rising edge at terminal count, a gate-triggered one-shot pulse, a periodic one-tick strobe, a square wave, and one-tick low strobes started either by software or by a gate edge.

A register interface outside this block assembles bytes and decodes addresses. It gives the channel a mode and number-format strobe (`cfg_wr`) and a full count value with its own strobe (`cnt_wr`). The channel reports the live counting element, the output level and a flag that shows a written count has not yet reached the counting element. Both strobes are single-cycle control pulses. They are taken in the cycle they are asserted and have no ready or back-pressure. In a cycle that carries a strobe, the gate edge and the tick of that cycle are dropped.

Top module: `interval_counter_channel`

## Requirements
- R1: Mode codes 6 (binary 110) and 7 (binary 111) act exactly as codes 2 and 3. The mode code is `cfg_mode[2:0]`, and `cfg_bcd`=1 selects decimal counting.
- R2: A count of 0 stands for 65536 in binary and 10000 in decimal. Stepping down from 0 gives 0xFFFF in binary and 0x9999 in decimal.
- R3: Any `cfg_wr` or `cnt_wr` sets `null_cnt`. The first tick after the load condition copies the count register into `elem_value` and clears `null_cnt`, and counting starts on the tick after that. Cycles without `tick` leave `elem_value` unchanged.
- R4: Mode 0: writing a count N drives `out_o` low. `out_o` goes high N+1 ticks after the write and stays high while the element keeps wrapping down.
- R5: Mode 1: after a count write nothing loads until a rising gate edge. The edge drives `out_o` low, and `out_o` returns high N+1 ticks later. With the gate held high from reset, no edge is seen.
- R6: Mode 2: `out_o` is high and drops for exactly one tick when the element reaches 1. The next tick reloads the element and raises `out_o`, which gives a period of N ticks.
- R7: Mode 3 steps by two. For a count N, the high phase lasts ceil(N/2) ticks and the low phase lasts floor(N/2) ticks, and `out_o` toggles on each reload. The first high phase also includes the load tick.
- R8: Modes 4 and 5 hold `out_o` high and pull it low for exactly one tick, N+1 ticks after the start, with no reload. Mode 4 starts on the count write and mode 5 on a rising gate edge.
- R9: A low gate halts counting in modes 0, 2, 3 and 4. In modes 2 and 3 a low gate also forces `out_o` high, and a rising edge while counting reloads from the count register.
- R10: In modes 2 and 3, a count written while counting does not disturb the current period. The new value is used at the next reload.
- R11: After reset `out_o`=0, `null_cnt`=1, `elem_value`=0 and the mode is 0. The sampled gate level starts at the parameter `GATE_RESET`.
- R12: `cfg_wr` clears the element and the count register and stops counting. It sets `out_o` low for mode 0 and high for every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one pulse per counter tick |
| gate_in | input | 1 | Gate level, synchronous to clk |
| cfg_wr | input | 1 | Mode/format write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_bcd | input | 1 | 1 = four-digit decimal counting |
| cnt_wr | input | 1 | Count value write strobe |
| cnt_val | input | COUNT_W | Full count value |
| elem_value | output | COUNT_W | Current counting element |
| out_o | output | 1 | Channel output |
| null_cnt | output | 1 | Written count not yet transferred |

## Verification
The bench measures the exact number of ticks between output transitions. An off-by-one in the load tick, or in the extra half-step that an odd square-wave count adds to the high phase, shows up as a tick count that is one too high or one too low. The zero-count runs in both number formats catch a counter that treats 0 as empty or wraps to 0xFFFF in decimal. Gate tests check three things: that the count freezes in the halting modes, that a low gate lifts the output in modes 2 and 3 (a missed force leaves it low), and that a rising edge restarts the period. A rewrite in the middle of a period checks that the current period still finishes on the old value rather than being cut short.

// File: rtl/ictr_pkg.sv
package ictr_pkg;
  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LOAD,
    ST_RUN,
    ST_TAIL
  } st_e;

  // codes 6 and 7 fold onto 2 and 3
  function automatic mode_e norm_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return mode_e'({1'b0, code[1:0]});
    return mode_e'(code);
  endfunction

  function automatic logic gate_halts(input mode_e m);
    return (m == M_TERM) || (m == M_RATE) || (m == M_SQUARE) || (m == M_SWSTROBE);
  endfunction
endpackage

// File: rtl/ictr_gate_edge.sv
module ictr_gate_edge #(
  parameter logic RESET_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= RESET_LEVEL;
    else        gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/ictr_decrement.sv
module ictr_decrement #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic         bcd_i,
  input  logic         by_two_i,
  output logic [W-1:0] res_o
);
  localparam int DIGITS = W / 4;

  logic [DIGITS:0] brw;
  logic [W-1:0]    dec_res;
  logic [W-1:0]    bin_res;

  assign brw[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [2:0] sub;
    logic [4:0] diff;
    assign sub  = (g == 0) ? (by_two_i ? 3'd2 : 3'd1) : 3'd0;
    assign diff = {1'b0, val_i[g*4 +: 4]} - {2'b00, sub} - {4'b0000, brw[g]};
    assign dec_res[g*4 +: 4] = diff[4] ? (diff[3:0] + 4'd10) : diff[3:0];
    assign brw[g+1] = diff[4];
  end

  assign bin_res = val_i - (by_two_i ? W'(2) : W'(1));
  assign res_o   = bcd_i ? dec_res : bin_res;
endmodule

// File: rtl/interval_counter_channel.sv
module interval_counter_channel
  import ictr_pkg::*;
#(
  parameter int   COUNT_W    = 16,
  parameter logic GATE_RESET = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               gate_in,
  input  logic               cfg_wr,
  input  logic [2:0]         cfg_mode,
  input  logic               cfg_bcd,
  input  logic               cnt_wr,
  input  logic [COUNT_W-1:0] cnt_val,
  output logic [COUNT_W-1:0] elem_value,
  output logic               out_o,
  output logic               null_cnt
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);
  localparam logic [COUNT_W-1:0] TWO = COUNT_W'(2);

  mode_e              mode_q;
  st_e                st_q;
  logic               bcd_q;
  logic [COUNT_W-1:0] cr_q, ce_q;
  logic               out_q, null_q;

  logic               gate_rise;
  logic               per_two, halt, take_edge;
  logic [COUNT_W-1:0] dec_in, dec_res, per;

  ictr_gate_edge #(.RESET_LEVEL(GATE_RESET)) u_edge (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_in), .rise_o(gate_rise)
  );

  assign per_two = (mode_q == M_SQUARE);
  assign per     = per_two ? TWO : ONE;
  assign dec_in  = per_two ? {ce_q[COUNT_W-1:1], 1'b0} : ce_q;
  assign halt    = !gate_in && gate_halts(mode_q);

  ictr_decrement #(.W(COUNT_W)) u_dec (
    .val_i(dec_in), .bcd_i(bcd_q),
    .by_two_i(per_two && st_q == ST_RUN), .res_o(dec_res)
  );

  always_comb begin
    take_edge = 1'b0;
    if (gate_rise) begin
      case (mode_q)
        M_ONESHOT, M_HWSTROBE: take_edge = (st_q == ST_ARMED);
        M_RATE, M_SQUARE:      take_edge = (st_q == ST_RUN);
        default:               take_edge = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_TERM;
      bcd_q  <= 1'b0;
      st_q   <= ST_IDLE;
      cr_q   <= '0;
      ce_q   <= '0;
      out_q  <= 1'b0;
      null_q <= 1'b1;
    end else if (cfg_wr) begin
      mode_q <= norm_mode(cfg_mode);
      bcd_q  <= cfg_bcd;
      st_q   <= ST_IDLE;
      cr_q   <= '0;
      ce_q   <= '0;
      null_q <= 1'b1;
      out_q  <= (norm_mode(cfg_mode) != M_TERM);
    end else if (cnt_wr) begin
      cr_q   <= cnt_val;
      null_q <= 1'b1;
      case (mode_q)
        M_TERM: begin
          st_q  <= ST_LOAD;
          out_q <= 1'b0;
        end
        M_ONESHOT, M_HWSTROBE: st_q <= ST_ARMED;
        M_RATE, M_SQUARE: if (st_q != ST_RUN) st_q <= ST_LOAD;
        default: st_q <= ST_LOAD;
      endcase
    end else begin
      if ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate_in) out_q <= 1'b1;
      if (take_edge) begin
        st_q <= ST_LOAD;
        if (mode_q == M_ONESHOT) out_q <= 1'b0;
      end else if (tick) begin
        case (st_q)
          ST_LOAD: begin
            ce_q   <= cr_q;
            null_q <= 1'b0;
            st_q   <= ST_RUN;
          end
          ST_RUN: if (!halt) begin
            if (per_two && ce_q[0] && out_q) begin
              ce_q <= dec_in;                 // odd count: extra high half-step
            end else if (dec_in == per) begin
              ce_q <= '0;
              case (mode_q)
                M_TERM, M_ONESHOT: begin
                  out_q <= 1'b1;
                  st_q  <= ST_TAIL;
                end
                M_RATE: begin
                  out_q  <= 1'b1;
                  ce_q   <= cr_q;
                  null_q <= 1'b0;
                end
                M_SQUARE: begin
                  out_q  <= ~out_q;
                  ce_q   <= cr_q;
                  null_q <= 1'b0;
                end
                default: begin
                  out_q <= 1'b0;
                  st_q  <= ST_TAIL;
                end
              endcase
            end else begin
              ce_q <= dec_res;
              if (mode_q == M_RATE && dec_res == ONE) out_q <= 1'b0;
            end
          end
          ST_TAIL: if (!halt) begin
            ce_q  <= dec_res;
            out_q <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign elem_value = ce_q;
  assign out_o      = out_q;
  assign null_cnt   = null_q;

  // any write marks the count as not yet transferred
  assert_null_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr || cnt_wr) |=> null_cnt);

  // the transfer tick clears the flag
  assert_load_clears_null_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOAD && tick && !cfg_wr && !cnt_wr) |=> !null_cnt);

  assert_mode0_write_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !cfg_wr && mode_q == M_TERM) |=> !out_o);

  assert_rate_pulse_one_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && st_q == ST_RUN && !out_o && gate_in && tick && !cfg_wr && !cnt_wr)
    |=> out_o);

  assert_gate_forces_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == M_RATE || mode_q == M_SQUARE) && !gate_in && !cfg_wr) |=> out_o);

  assert_gate_halts_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && (st_q == ST_RUN || st_q == ST_TAIL) && !cfg_wr && !cnt_wr) |=> $stable(elem_value));

  assert_cfg_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_mode == 3'd0) |=> (!out_o && elem_value == '0));
endmodule

// File: tb/interval_counter_channel_tb.sv
module interval_counter_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct packed {
    logic [2:0]  mode;
    logic        bcd;
    logic [15:0] count;
    logic        out0;
    logic [15:0] ticks;
  } vec_t;

  // mode, bcd, count, level after write, ticks to first transition
  localparam vec_t VEC [8] = '{
    '{3'd0, 1'b0, 16'd5,     1'b0, 16'd6},
    '{3'd4, 1'b0, 16'd5,     1'b1, 16'd6},
    '{3'd2, 1'b0, 16'd5,     1'b1, 16'd5},
    '{3'd3, 1'b0, 16'd7,     1'b1, 16'd5},
    '{3'd6, 1'b0, 16'd4,     1'b1, 16'd4},
    '{3'd7, 1'b0, 16'd6,     1'b1, 16'd4},
    '{3'd0, 1'b1, 16'h0010,  1'b0, 16'd11},
    '{3'd3, 1'b1, 16'h0011,  1'b1, 16'd7}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, gate_in = 1'b1;
  logic cfg_wr = 1'b0, cfg_bcd = 1'b0, cnt_wr = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [W-1:0] cnt_val = '0;
  logic [W-1:0] elem_value;
  logic out_o, null_cnt;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] held;

  always #(CLK_PERIOD/2) clk = ~clk;

  interval_counter_channel u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate_in(gate_in),
    .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
    .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .elem_value(elem_value), .out_o(out_o), .null_cnt(null_cnt)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_cfg(input logic [2:0] m, input logic b);
    cfg_mode = m; cfg_bcd = b; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_write(input logic [W-1:0] v);
    cnt_val = v; cnt_wr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0;
  endtask

  task automatic do_ticks(input int k);
    tick = 1'b1;
    repeat (k) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ticks_to_toggle(output int n);
    logic prev;
    prev = out_o;
    n = 0;
    tick = 1'b1;
    while (n < 70000) begin
      @(negedge clk);
      n++;
      if (out_o != prev) break;
    end
    tick = 1'b0;
  endtask

  task automatic gate_pulse();
    gate_in = 1'b0;
    @(negedge clk);
    gate_in = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 out", out_o, 0);
    check("R11 null", null_cnt, 1);
    check("R11 elem", elem_value, 0);

    // R1 R4 R6 R7 R8 table walk
    foreach (VEC[i]) begin
      do_cfg(VEC[i].mode, VEC[i].bcd);
      do_write(VEC[i].count);
      check($sformatf("R1 vec%0d initial level", i), out_o, VEC[i].out0);
      ticks_to_toggle(n);
      check($sformatf("R1 vec%0d ticks", i), n, VEC[i].ticks);
      check($sformatf("R1 vec%0d level", i), out_o, !VEC[i].out0);
    end

    // R3 transfer timing and tick enable
    do_cfg(3'd0, 1'b0);
    do_write(16'd3);
    check("R3 null after write", null_cnt, 1);
    check("R3 elem before tick", elem_value, 0);
    do_ticks(1);
    check("R3 elem loaded", elem_value, 3);
    check("R3 null cleared", null_cnt, 0);
    repeat (2) @(negedge clk);
    check("R3 no tick no step", elem_value, 3);
    do_ticks(1);
    check("R3 first step", elem_value, 2);

    // R2 wrap below zero, binary and decimal
    do_cfg(3'd0, 1'b0);
    do_write(16'd2);
    do_ticks(3);
    check("R4 terminal out", out_o, 1);
    check("R2 bin at zero", elem_value, 0);
    do_ticks(1);
    check("R2 bin wrap", elem_value, 16'hFFFF);
    check("R4 stays high", out_o, 1);
    do_cfg(3'd0, 1'b1);
    do_write(16'd2);
    do_ticks(4);
    check("R2 bcd wrap", elem_value, 16'h9999);

    // R2 zero count means full range
    do_cfg(3'd0, 1'b0);
    do_write(16'd0);
    ticks_to_toggle(n);
    check("R2 bin zero count", n, 65537);
    do_cfg(3'd0, 1'b1);
    do_write(16'd0);
    ticks_to_toggle(n);
    check("R2 bcd zero count", n, 10001);

    // R5 R11 one-shot: gate high since reset gives no edge
    do_cfg(3'd1, 1'b0);
    check("R5 level after cfg", out_o, 1);
    do_write(16'd3);
    do_ticks(5);
    check("R11 no edge from reset level", out_o, 1);
    check("R5 not loaded", elem_value, 0);
    gate_pulse();
    check("R5 trigger low", out_o, 0);
    ticks_to_toggle(n);
    check("R5 ticks", n, 4);
    check("R5 end level", out_o, 1);

    // R8 gate-started strobe
    do_cfg(3'd5, 1'b0);
    do_write(16'd3);
    gate_pulse();
    check("R8 still high", out_o, 1);
    ticks_to_toggle(n);
    check("R8 strobe delay", n, 4);
    ticks_to_toggle(n);
    check("R8 strobe width", n, 1);
    check("R8 back high", out_o, 1);

    // R6 rate period
    do_cfg(3'd2, 1'b0);
    do_write(16'd5);
    ticks_to_toggle(n);
    check("R6 first drop", n, 5);
    ticks_to_toggle(n);
    check("R6 pulse width", n, 1);
    ticks_to_toggle(n);
    check("R6 next drop", n, 4);

    // R7 odd square wave, binary and decimal
    do_cfg(3'd3, 1'b0);
    do_write(16'd5);
    ticks_to_toggle(n);
    check("R7 first high", n, 4);
    ticks_to_toggle(n);
    check("R7 low phase", n, 2);
    ticks_to_toggle(n);
    check("R7 high phase", n, 3);
    do_cfg(3'd3, 1'b1);
    do_write(16'h1001);
    ticks_to_toggle(n);
    check("R7 bcd first high", n, 502);
    ticks_to_toggle(n);
    check("R7 bcd low", n, 500);
    ticks_to_toggle(n);
    check("R7 bcd high", n, 501);

    // R9 gate halts mode 0
    do_cfg(3'd0, 1'b0);
    do_write(16'd10);
    do_ticks(3);
    check("R9 before halt", elem_value, 8);
    gate_in = 1'b0;
    do_ticks(5);
    check("R9 halted count", elem_value, 8);
    check("R9 mode0 out", out_o, 0);
    gate_in = 1'b1;
    do_ticks(1);
    check("R9 resumed", elem_value, 7);

    // R9 mode 3: low gate forces high, rise reloads
    do_cfg(3'd3, 1'b0);
    do_write(16'd8);
    ticks_to_toggle(n);
    check("R9 sq low reached", out_o, 0);
    gate_in = 1'b0;
    @(negedge clk);
    check("R9 forced high", out_o, 1);
    held = elem_value;
    do_ticks(3);
    check("R9 sq halted", elem_value, held);
    gate_in = 1'b1;
    @(negedge clk);
    do_ticks(1);
    check("R9 restart from register", elem_value, 8);
    check("R9 restart level", out_o, 1);

    // R10 rewrite mid-period
    do_cfg(3'd2, 1'b0);
    do_write(16'd5);
    do_ticks(2);
    check("R10 running", elem_value, 4);
    do_write(16'd3);
    check("R10 element untouched", elem_value, 4);
    ticks_to_toggle(n);
    check("R10 old period finishes", n, 3);
    do_ticks(1);
    check("R10 new value at reload", elem_value, 3);
    ticks_to_toggle(n);
    check("R10 new period", n, 2);

    // R12 control write
    do_cfg(3'd2, 1'b0);
    check("R12 high level", out_o, 1);
    check("R12 elem cleared", elem_value, 0);
    check("R12 null set", null_cnt, 1);
    do_ticks(3);
    check("R12 stopped", elem_value, 0);
    do_cfg(3'd0, 1'b0);
    check("R12 low level", out_o, 0);

    finish_run();
  end
endmodule